// File: doc/BRIEF.md
# Key Trigger Decoder with Debounce

This block sits between a bank of eight push-button trigger pins plus one step button and a voice playback engine. It synchronises and debounces the pins, looks up the settled pin pattern in a fixed table of 32 codes, and emits a one-cycle play request that carries a voice group number and that group's three playback options. The table is built from runs of one to four neighbouring high pins that wrap from the last pin back to the first. A run of length L starting at pin s (s counted from 0) selects group (L-1)*8 + s + 1. The step button reaches the groups above 32 one at a time.

The playback engine reports a busy level, a done pulse and a ramp-down-finished pulse. From these the block decides three things. It decides whether a press during playback may restart the sound. It decides whether releasing a holdable group's key must stop it. It decides whether a level-triggered group must play again because its key is still down when playback ends. Debounce windows count a fast timing tick, and the post-ramp lockout counts a sample tick. Every window length is a parameter.

Top module: `key_trig_decoder`

## Requirements
- R1: After reset, req_valid_o and stop_o are low, and the step pointer holds group KEY_GROUPS+1, which is 33 with the defaults.
- R2: A settled pattern with only pin n high (keys_i bit n-1, n = 1..8) requests group n.
- R3: A settled run of 2, 3 or 4 adjacent high pins requests group (L-1)*8 + s + 1. Here L is the run length and s is the index of the first pin in the run. The run wraps from bit 7 to bit 0, so bits {7,0} give 16, bits {6,7,0} give 23 and bits {7,0,1,2} give 32.
- R4: A settled pattern that is not one of the 32 table codes raises neither a request nor a stop.
- R5: A change on keys_i or seq_btn_i must stay unchanged for LIM fast ticks before it takes effect. LIM is DEB_SHORT when long_deb_i=0 and DEB_LONG when long_deb_i=1. A change that reverts sooner has no effect. With fast_tick_i held high, the resulting request or stop is on the outputs SYNC_STAGES+LIM+2 clock edges after the input changes.
- R6: When busy_i is high and the active group is retriggerable, the windows become DEB_SHORT_RT or DEB_LONG_RT. A new press is then accepted and requested.
- R7: When busy_i is high and the active group is not retriggerable, key and step presses are ignored.
- R8: Each settled step-button press requests the step pointer's group and then advances the pointer by one. After LAST_GROUP the pointer returns to KEY_GROUPS+1. The request carries seq_edge_i, seq_hold_i and seq_retrig_i.
- R9: After a ramp_end_i pulse, presses and replays are ignored until LOCK_SAMPLES sample_tick_i pulses have been counted.
- R10: When the active group is holdable, busy_i is high and its source (the key pattern or the step button) settles released, stop_o pulses for one cycle with the R5 latency.
- R11: A play_done_i pulse while the active group is level-triggered and its source still holds it raises a request for the same group on the next clock edge. An edge-triggered group raises none.
- R12: A request for key group g carries opt_edge_i, opt_hold_i and opt_retrig_i bit g-1 on req_edge_o, req_hold_o and req_retrig_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fast_tick_i | input | 1 | Debounce timing tick |
| sample_tick_i | input | 1 | One pulse per audio sample period |
| long_deb_i | input | 1 | Chip-wide selector: 1 long windows, 0 short |
| keys_i | input | NUM_KEYS | Raw trigger pins, bit 0 is pin 1 |
| seq_btn_i | input | 1 | Raw step button |
| opt_edge_i | input | KEY_GROUPS | Per key group: 1 edge-triggered, 0 level |
| opt_hold_i | input | KEY_GROUPS | Per key group: 1 holdable |
| opt_retrig_i | input | KEY_GROUPS | Per key group: 1 retriggerable |
| seq_edge_i | input | 1 | Edge option for step groups |
| seq_hold_i | input | 1 | Hold option for step groups |
| seq_retrig_i | input | 1 | Retrigger option for step groups |
| busy_i | input | 1 | Playback in progress |
| play_done_i | input | 1 | Pulse: playback of the active group ended |
| ramp_end_i | input | 1 | Pulse: output ramp-down finished |
| req_valid_o | output | 1 | One-cycle play request |
| req_group_o | output | GROUP_W | Requested group number |
| req_edge_o | output | 1 | Edge option of the requested group |
| req_hold_o | output | 1 | Hold option of the requested group |
| req_retrig_o | output | 1 | Retrigger option of the requested group |
| stop_o | output | 1 | One-cycle stop of the active group |

## Verification
Presses and releases pass through SYNC_STAGES synchroniser flops and a debounce window of LIM ticks, then take one edge for the event compare and one for the output register. Each expected request or stop is therefore due SYNC_STAGES+LIM+2 edges after the bench changes the pins, and a replay after play_done_i is due one edge later. When the bench drives a stimulus it stamps the expected item with its due cycle. The monitor samples on the falling edge and demands that the item arrive in exactly that cycle. Cases that must produce nothing are checked over a window longer than the longest debounce.

// File: rtl/ktd_pkg.sv
package ktd_pkg;

    typedef struct packed {
        logic edge_trig;
        logic holdable;
        logic retrig;
    } grp_opt_t;

    typedef enum logic {
        SRC_KEY = 1'b0,
        SRC_SEQ = 1'b1
    } trig_src_t;

endpackage

// File: rtl/ktd_sync_deb.sv
module ktd_sync_deb #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] stable_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][WIDTH-1:0] sync;
        logic [WIDTH-1:0]                  cand;
        logic [WIDTH-1:0]                  stable;
        logic [CNT_W-1:0]                  cnt;
    } deb_state_t;

    deb_state_t q, d;
    logic [WIDTH-1:0] settled;
    logic [CNT_W:0]   next_cnt;

    always_comb begin
        d = q;
        d.sync[0] = raw_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            d.sync[i] = q.sync[i-1];
        end
        settled  = q.sync[SYNC_STAGES-1];
        next_cnt = {1'b0, q.cnt} + 1'b1;
        if (settled != q.cand) begin
            // any movement restarts the window
            d.cand = settled;
            d.cnt  = '0;
        end else if (tick_i && (q.stable != q.cand)) begin
            if (next_cnt >= {1'b0, limit_i}) begin
                d.stable = q.cand;
            end else begin
                d.cnt = next_cnt[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stable_o = q.stable;

endmodule

// File: rtl/ktd_pattern_dec.sv
module ktd_pattern_dec #(
    parameter int NUM_KEYS = 8,
    parameter int MAX_RUN  = 4,
    parameter int GROUP_W  = 8
) (
    input  logic [NUM_KEYS-1:0] pattern_i,
    output logic                hit_o,
    output logic [GROUP_W-1:0]  group_o
);

    function automatic logic [NUM_KEYS-1:0] run_mask(input int first, input int len);
        logic [NUM_KEYS-1:0] m;
        m = '0;
        for (int b = 0; b < len; b++) begin
            m[(first + b) % NUM_KEYS] = 1'b1;
        end
        return m;
    endfunction

    always_comb begin
        hit_o   = 1'b0;
        group_o = '0;
        for (int len = 1; len <= MAX_RUN; len++) begin
            for (int st = 0; st < NUM_KEYS; st++) begin
                if (pattern_i == run_mask(st, len)) begin
                    hit_o   = 1'b1;
                    group_o = GROUP_W'((len - 1) * NUM_KEYS + st + 1);
                end
            end
        end
    end

endmodule

// File: rtl/ktd_lockout.sv
module ktd_lockout #(
    parameter int LOCK_SAMPLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic locked_o
);

    localparam int LOCK_W = $clog2(LOCK_SAMPLES + 1);

    logic [LOCK_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = LOCK_W'(LOCK_SAMPLES);
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign locked_o = (cnt_q != '0);

endmodule

// File: rtl/key_trig_decoder.sv
module key_trig_decoder
    import ktd_pkg::*;
#(
    parameter int NUM_KEYS     = 8,
    parameter int MAX_RUN      = 4,
    parameter int GROUP_W      = 8,
    parameter int LAST_GROUP   = 254,
    parameter int SYNC_STAGES  = 2,
    parameter int DEB_SHORT    = 65,
    parameter int DEB_LONG     = 16000,
    parameter int DEB_SHORT_RT = 200,
    parameter int DEB_LONG_RT  = 24000,
    parameter int LOCK_SAMPLES = 256
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fast_tick_i,
    input  logic                           sample_tick_i,
    input  logic                           long_deb_i,
    input  logic [NUM_KEYS-1:0]            keys_i,
    input  logic                           seq_btn_i,
    input  logic [NUM_KEYS*MAX_RUN-1:0]    opt_edge_i,
    input  logic [NUM_KEYS*MAX_RUN-1:0]    opt_hold_i,
    input  logic [NUM_KEYS*MAX_RUN-1:0]    opt_retrig_i,
    input  logic                           seq_edge_i,
    input  logic                           seq_hold_i,
    input  logic                           seq_retrig_i,
    input  logic                           busy_i,
    input  logic                           play_done_i,
    input  logic                           ramp_end_i,
    output logic                           req_valid_o,
    output logic [GROUP_W-1:0]             req_group_o,
    output logic                           req_edge_o,
    output logic                           req_hold_o,
    output logic                           req_retrig_o,
    output logic                           stop_o
);

    localparam int KEY_GROUPS = NUM_KEYS * MAX_RUN;
    localparam int FIRST_SEQ  = KEY_GROUPS + 1;
    localparam int KG_W       = $clog2(KEY_GROUPS);
    localparam int MAX_A      = (DEB_SHORT > DEB_LONG) ? DEB_SHORT : DEB_LONG;
    localparam int MAX_B      = (DEB_SHORT_RT > DEB_LONG_RT) ? DEB_SHORT_RT : DEB_LONG_RT;
    localparam int DEB_MAX    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W      = $clog2(DEB_MAX + 1);

    typedef struct packed {
        logic [NUM_KEYS-1:0] keys_prev;
        logic                seq_prev;
        logic [GROUP_W-1:0]  seq_ptr;
        logic                act_valid;
        logic [GROUP_W-1:0]  act_group;
        grp_opt_t            act_opt;
        trig_src_t           act_src;
        logic                req_valid;
        logic [GROUP_W-1:0]  req_group;
        grp_opt_t            req_opt;
        logic                stop;
    } ctl_state_t;

    ctl_state_t q, d;

    // debounce window selection
    logic             retrig_win;
    logic [CNT_W-1:0] deb_limit;

    always_comb begin
        retrig_win = q.act_valid && q.act_opt.retrig && busy_i;
        case ({retrig_win, long_deb_i})
            2'b00:   deb_limit = CNT_W'(DEB_SHORT);
            2'b01:   deb_limit = CNT_W'(DEB_LONG);
            2'b10:   deb_limit = CNT_W'(DEB_SHORT_RT);
            default: deb_limit = CNT_W'(DEB_LONG_RT);
        endcase
    end

    // input conditioning, one instance per source
    logic [NUM_KEYS-1:0] keys_st;
    logic [0:0]          seq_st_v;
    logic                seq_st;

    ktd_sync_deb #(
        .WIDTH       (NUM_KEYS),
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (CNT_W)
    ) u_key_deb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (fast_tick_i),
        .limit_i  (deb_limit),
        .raw_i    (keys_i),
        .stable_o (keys_st)
    );

    ktd_sync_deb #(
        .WIDTH       (1),
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (CNT_W)
    ) u_seq_deb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (fast_tick_i),
        .limit_i  (deb_limit),
        .raw_i    (seq_btn_i),
        .stable_o (seq_st_v)
    );

    assign seq_st = seq_st_v[0];

    logic               key_hit;
    logic [GROUP_W-1:0] key_grp;

    ktd_pattern_dec #(
        .NUM_KEYS (NUM_KEYS),
        .MAX_RUN  (MAX_RUN),
        .GROUP_W  (GROUP_W)
    ) u_dec (
        .pattern_i (keys_st),
        .hit_o     (key_hit),
        .group_o   (key_grp)
    );

    logic locked;

    ktd_lockout #(
        .LOCK_SAMPLES (LOCK_SAMPLES)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (ramp_end_i),
        .tick_i   (sample_tick_i),
        .locked_o (locked)
    );

    // option lookup for the decoded key group
    logic [KG_W-1:0] kidx;
    grp_opt_t        key_opt;
    grp_opt_t        seq_opt;

    always_comb begin
        kidx              = KG_W'(key_grp - GROUP_W'(1));
        key_opt.edge_trig = opt_edge_i[kidx];
        key_opt.holdable  = opt_hold_i[kidx];
        key_opt.retrig    = opt_retrig_i[kidx];
        seq_opt.edge_trig = seq_edge_i;
        seq_opt.holdable  = seq_hold_i;
        seq_opt.retrig    = seq_retrig_i;
    end

    // event detection and request arbitration
    logic               key_press, key_release, seq_press, seq_release;
    logic               press_ok, src_held, src_released;
    logic               issue;
    logic [GROUP_W-1:0] iss_group;
    grp_opt_t           iss_opt;
    trig_src_t          iss_src;

    always_comb begin
        d           = q;
        d.req_valid = 1'b0;
        d.stop      = 1'b0;
        d.keys_prev = keys_st;
        d.seq_prev  = seq_st;

        key_press   = key_hit && (keys_st != q.keys_prev);
        key_release = (keys_st == '0) && (q.keys_prev != '0);
        seq_press   = seq_st && !q.seq_prev;
        seq_release = !seq_st && q.seq_prev;

        press_ok = !locked && (!busy_i || (q.act_valid && q.act_opt.retrig));

        if (q.act_src == SRC_KEY) begin
            src_held     = key_hit && (key_grp == q.act_group);
            src_released = key_release;
        end else begin
            src_held     = seq_st;
            src_released = seq_release;
        end

        issue     = 1'b0;
        iss_group = q.act_group;
        iss_opt   = q.act_opt;
        iss_src   = q.act_src;

        if (key_press && press_ok) begin
            issue     = 1'b1;
            iss_group = key_grp;
            iss_opt   = key_opt;
            iss_src   = SRC_KEY;
        end else if (seq_press && press_ok) begin
            issue     = 1'b1;
            iss_group = q.seq_ptr;
            iss_opt   = seq_opt;
            iss_src   = SRC_SEQ;
            d.seq_ptr = (q.seq_ptr == GROUP_W'(LAST_GROUP)) ? GROUP_W'(FIRST_SEQ)
                                                             : q.seq_ptr + 1'b1;
        end else if (play_done_i && q.act_valid) begin
            if (!q.act_opt.edge_trig && src_held && !locked) begin
                issue = 1'b1;    // level group still held: play again
            end else begin
                d.act_valid = 1'b0;
            end
        end else if (q.act_valid && q.act_opt.holdable && busy_i && src_released) begin
            d.stop      = 1'b1;
            d.act_valid = 1'b0;
        end

        if (issue) begin
            d.req_valid = 1'b1;
            d.req_group = iss_group;
            d.req_opt   = iss_opt;
            d.act_valid = 1'b1;
            d.act_group = iss_group;
            d.act_opt   = iss_opt;
            d.act_src   = iss_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.seq_ptr <= GROUP_W'(FIRST_SEQ);
        end else begin
            q <= d;
        end
    end

    assign req_valid_o  = q.req_valid;
    assign req_group_o  = q.req_group;
    assign req_edge_o   = q.req_opt.edge_trig;
    assign req_hold_o   = q.req_opt.holdable;
    assign req_retrig_o = q.req_opt.retrig;
    assign stop_o       = q.stop;

endmodule

// File: rtl/ktd_checker.sv
module ktd_checker #(
    parameter int GROUP_W      = 8,
    parameter int LAST_GROUP   = 254,
    parameter int KEY_GROUPS   = 32,
    parameter int LOCK_SAMPLES = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_tick_i,
    input logic               ramp_end_i,
    input logic               busy_i,
    input logic               seq_edge_i,
    input logic               req_valid_o,
    input logic [GROUP_W-1:0] req_group_o,
    input logic               req_edge_o,
    input logic               stop_o
);

    localparam int CW = $clog2(LOCK_SAMPLES + 1);

    logic [CW-1:0] win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (ramp_end_i) begin
            win_cnt <= CW'(LOCK_SAMPLES);
        end else if (sample_tick_i && (win_cnt != '0)) begin
            win_cnt <= win_cnt - 1'b1;
        end
    end

    // requested group always lies in 1..LAST_GROUP (R2, R3, R8)
    assert_group_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_group_o != '0) && (req_group_o <= GROUP_W'(LAST_GROUP)));

    // a request and a stop never share a cycle (R10)
    assert_req_stop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_o && stop_o));

    // a stop is only raised while playback was running (R10)
    assert_stop_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> $past(busy_i));

    // nothing is requested inside the post-ramp window (R9)
    assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> ($past(win_cnt) == '0));

    // step groups carry the step edge option (R8)
    assert_seq_opt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && (req_group_o > GROUP_W'(KEY_GROUPS))) |-> (req_edge_o == $past(seq_edge_i)));

endmodule

bind key_trig_decoder ktd_checker #(
    .GROUP_W      (GROUP_W),
    .LAST_GROUP   (LAST_GROUP),
    .KEY_GROUPS   (NUM_KEYS * MAX_RUN),
    .LOCK_SAMPLES (LOCK_SAMPLES)
) u_ktd_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_tick_i (sample_tick_i),
    .ramp_end_i    (ramp_end_i),
    .busy_i        (busy_i),
    .seq_edge_i    (seq_edge_i),
    .req_valid_o   (req_valid_o),
    .req_group_o   (req_group_o),
    .req_edge_o    (req_edge_o),
    .stop_o        (stop_o)
);

// File: tb/key_trig_decoder_test.sv
module key_trig_decoder_test;

    localparam int SYNC   = 2;
    localparam int SH     = 3;
    localparam int LG     = 6;
    localparam int SH_RT  = 5;
    localparam int LG_RT  = 8;
    localparam int LOCK   = 20;
    localparam int LAST   = 35;
    localparam int SETTLE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b1;
    logic        sample_tick = 1'b1;
    logic        long_deb = 1'b0;
    logic [7:0]  keys = '0;
    logic        seq_btn = 1'b0;
    logic [31:0] opt_edge, opt_hold, opt_retrig;
    logic        seq_edge = 1'b1, seq_hold = 1'b0, seq_retrig = 1'b0;
    logic        busy = 1'b0, play_done = 1'b0, ramp_end = 1'b0;
    logic        req_valid, req_edge, req_hold, req_retrig, stop;
    logic [7:0]  req_group;

    // group 2 retriggerable, group 3 holdable, group 5 edge, group 32 all three
    initial begin
        opt_edge   = 32'h8000_0010;
        opt_hold   = 32'h8000_0004;
        opt_retrig = 32'h8000_0002;
    end

    key_trig_decoder #(
        .LAST_GROUP   (LAST),
        .SYNC_STAGES  (SYNC),
        .DEB_SHORT    (SH),
        .DEB_LONG     (LG),
        .DEB_SHORT_RT (SH_RT),
        .DEB_LONG_RT  (LG_RT),
        .LOCK_SAMPLES (LOCK)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .fast_tick_i (fast_tick), .sample_tick_i (sample_tick),
        .long_deb_i (long_deb), .keys_i (keys), .seq_btn_i (seq_btn),
        .opt_edge_i (opt_edge), .opt_hold_i (opt_hold), .opt_retrig_i (opt_retrig),
        .seq_edge_i (seq_edge), .seq_hold_i (seq_hold), .seq_retrig_i (seq_retrig),
        .busy_i (busy), .play_done_i (play_done), .ramp_end_i (ramp_end),
        .req_valid_o (req_valid), .req_group_o (req_group),
        .req_edge_o (req_edge), .req_hold_o (req_hold), .req_retrig_o (req_retrig),
        .stop_o (stop)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0, unexp = 0, snap = 0;
    bit done = 1'b0;

    // scoreboard queues: kind 0 = request, 1 = stop
    bit         kind_q[$];
    logic [7:0] grp_q[$];
    logic [2:0] opt_q[$];
    int         due_q[$];
    string      tag_q[$];

    function automatic logic [2:0] exp_opt(input int g);
        if (g > 32) return {seq_edge, seq_hold, seq_retrig};
        return {opt_edge[g-1], opt_hold[g-1], opt_retrig[g-1]};
    endfunction

    task automatic push(input bit k, input int g, input int due, input string tag);
        kind_q.push_back(k);
        grp_q.push_back(8'(g));
        opt_q.push_back(k ? 3'b000 : exp_opt(g));
        due_q.push_back(due);
        tag_q.push_back(tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (req_valid || stop) begin
                checks++;
                if (kind_q.size() == 0) begin
                    errors++; unexp++;
                    $display("FAIL unexpected output at cyc %0d: req=%0b stop=%0b group=%0d, expected nothing",
                             cyc, req_valid, stop, req_group);
                end else begin
                    automatic bit         k = kind_q.pop_front();
                    automatic logic [7:0] g = grp_q.pop_front();
                    automatic logic [2:0] o = opt_q.pop_front();
                    automatic int         due = due_q.pop_front();
                    automatic string      t = tag_q.pop_front();
                    automatic bit bad = (k != stop) || (cyc != due) ||
                        (!k && ((req_group != g) || ({req_edge, req_hold, req_retrig} != o)));
                    if (bad) begin
                        errors++;
                        $display("FAIL %s: got stop=%0b group=%0d opt=%b cyc=%0d, expected stop=%0b group=%0d opt=%b cyc=%0d",
                                 t, stop, req_group, {req_edge, req_hold, req_retrig}, cyc, k, g, o, due);
                    end
                end
            end else if (due_q.size() > 0 && cyc > due_q[0]) begin
                automatic string t = tag_q.pop_front();
                checks++; errors++;
                $display("FAIL %s: got no output by cyc %0d, expected group %0d at cyc %0d",
                         t, cyc, grp_q[0], due_q[0]);
                void'(kind_q.pop_front()); void'(grp_q.pop_front());
                void'(opt_q.pop_front()); void'(due_q.pop_front());
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_keys(input logic [7:0] pat, input int lim, input int g, input string tag);
        @(negedge clk);
        keys = pat;
        if (g != 0) push(1'b0, g, cyc + SYNC + lim + 2, tag);
    endtask

    task automatic done_pulse;
        @(negedge clk); play_done = 1'b1;
        @(negedge clk); play_done = 1'b0;
    endtask

    task automatic tap(input logic [7:0] pat, input int g, input string tag);
        set_keys(pat, SH, g, tag);
        idle(SETTLE);
        set_keys(8'h00, SH, 0, tag);
        idle(SETTLE);
        done_pulse();
        idle(2);
    endtask

    task automatic seq_tap(input int g, input string tag);
        @(negedge clk); seq_btn = 1'b1;
        push(1'b0, g, cyc + SYNC + SH + 2, tag);
        idle(SETTLE);
        @(negedge clk); seq_btn = 1'b0;
        idle(SETTLE);
        done_pulse();
        idle(2);
    endtask

    task automatic quiet_begin;
        snap = unexp;
    endtask

    task automatic quiet_end(input string tag);
        checks++;
        if (unexp != snap || kind_q.size() != 0) begin
            errors++;
            $display("FAIL %s: got %0d unexpected outputs, expected 0", tag, unexp - snap);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got run still active, expected completion");
        finish_run();
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset
        checks++;
        if (req_valid !== 1'b0 || stop !== 1'b0) begin
            errors++;
            $display("FAIL R1: got req=%0b stop=%0b, expected 0 0", req_valid, stop);
        end
        idle(3);

        // R2: single pins
        tap(8'h01, 1, "R2 pin1");
        tap(8'h80, 8, "R2 pin8");
        tap(8'h10, 5, "R2 pin5 edge opt");

        // R3: runs with wraparound; R12 options on group 32
        tap(8'h03, 9,  "R3 pair 1-2");
        tap(8'h81, 16, "R3 pair wrap");
        tap(8'hC1, 23, "R3 triple wrap");
        tap(8'h0E, 18, "R3 triple 2-4");
        tap(8'h3C, 27, "R3 quad 3-6");
        tap(8'h87, 32, "R3 R12 quad wrap all options");

        // R4: patterns outside the table
        quiet_begin(); tap(8'h05, 0, "R4"); quiet_end("R4 gap pattern");
        quiet_begin(); tap(8'hFF, 0, "R4"); quiet_end("R4 all pins");
        quiet_begin(); tap(8'h1F, 0, "R4"); quiet_end("R4 run of five");

        // R5: short glitch ignored, long window timing
        quiet_begin();
        set_keys(8'h01, SH, 0, "R5");
        idle(1);
        set_keys(8'h00, SH, 0, "R5");
        idle(SETTLE);
        quiet_end("R5 glitch shorter than window");
        long_deb = 1'b1;
        set_keys(8'h04, LG, 3, "R5 long window");
        idle(SETTLE);
        set_keys(8'h00, LG, 0, "R5");
        idle(SETTLE);
        done_pulse();
        long_deb = 1'b0;
        idle(2);

        // R7: non-retriggerable group blocks presses while busy
        set_keys(8'h08, SH, 4, "R7 start group4");
        idle(SETTLE);
        @(negedge clk); busy = 1'b1;
        set_keys(8'h00, SH, 0, "R7");
        idle(SETTLE);
        quiet_begin();
        set_keys(8'h01, SH, 0, "R7");
        idle(SETTLE);
        set_keys(8'h00, SH, 0, "R7");
        idle(SETTLE);
        quiet_end("R7 press ignored during playback");
        @(negedge clk); busy = 1'b0;
        done_pulse();
        idle(2);

        // R6: retriggerable group, longer window during playback
        set_keys(8'h02, SH, 2, "R6 start group2");
        idle(SETTLE);
        @(negedge clk); busy = 1'b1;
        set_keys(8'h00, SH_RT, 0, "R6");
        idle(SETTLE);
        set_keys(8'h01, SH_RT, 1, "R6 retrigger window");
        idle(SETTLE);
        set_keys(8'h00, SH, 0, "R6");
        idle(SETTLE);
        @(negedge clk); busy = 1'b0;
        done_pulse();
        idle(2);

        // R10: release of a holdable group stops it
        set_keys(8'h04, SH, 3, "R10 start group3");
        idle(SETTLE);
        @(negedge clk); busy = 1'b1;
        set_keys(8'h00, SH, 0, "R10");
        push(1'b1, 0, cyc + SYNC + SH + 2, "R10 stop on release");
        idle(SETTLE);
        @(negedge clk); busy = 1'b0;
        idle(2);

        // R11: level group replays while held, edge group does not
        set_keys(8'h08, SH, 4, "R11 start level group");
        idle(SETTLE);
        @(negedge clk); busy = 1'b1;
        @(negedge clk); play_done = 1'b1;
        push(1'b0, 4, cyc + 1, "R11 replay while held");
        @(negedge clk); play_done = 1'b0;
        idle(4);
        set_keys(8'h00, SH, 0, "R11");
        idle(SETTLE);
        @(negedge clk); busy = 1'b0;
        done_pulse();
        idle(2);
        set_keys(8'h10, SH, 5, "R11 start edge group");
        idle(SETTLE);
        quiet_begin();
        done_pulse();
        idle(6);
        quiet_end("R11 edge group no replay");
        set_keys(8'h00, SH, 0, "R11");
        idle(SETTLE);

        // R8: step button walks 33..LAST and wraps
        seq_tap(33, "R8 first step group");
        seq_tap(34, "R8 step");
        seq_tap(35, "R8 last group");
        seq_tap(33, "R8 wrap");

        // R9: lockout after ramp-down
        @(negedge clk); ramp_end = 1'b1;
        @(negedge clk); ramp_end = 1'b0;
        quiet_begin();
        set_keys(8'h01, SH, 0, "R9");
        idle(SETTLE);
        set_keys(8'h00, SH, 0, "R9");
        idle(SETTLE);
        quiet_end("R9 press inside lockout");
        tap(8'h01, 1, "R9 press after lockout");

        idle(30);
        while (due_q.size() > 0) begin
            checks++; errors++;
            $display("FAIL %s: got nothing, expected group %0d at cyc %0d", tag_q[0], grp_q[0], due_q[0]);
            void'(kind_q.pop_front()); void'(grp_q.pop_front()); void'(opt_q.pop_front());
            void'(due_q.pop_front()); void'(tag_q.pop_front());
        end
        finish_run();
    end

endmodule